// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable behavioural model of a synchronous burst static RAM. Its word is 18 bits, made of two 9-bit bytes, and its depth is set by a parameter. Addresses, write data, chip enables, burst controls and write controls are all sampled on the rising clock edge. Output enable and sleep act on the data output at once, with no clock needed. Write data enters on one port and read data leaves on another. A valid flag stands in for a tri-stated bus.

A new access starts when either of two load strobes is high while the chip is selected. After that, a 2-bit beat counter can produce up to three more addresses. It steps on each advance cycle, in linear or interleaved order. No burst is required: a new external address can be loaded on every cycle. A mode input picks the read path. With flow-through, data appears after the edge that takes the address. With pipelined, it appears one edge later.

The control FSM has four states. ST_IDLE: no access in progress. ST_READ: the current beat reads. ST_WRITE: the current beat writes. ST_SLEEP: low power, with the memory held. Transitions at each edge:
- Sleep high: the FSM goes to ST_SLEEP from any state.
- A strobe with the chip selected: the FSM goes to ST_WRITE or ST_READ.
- A strobe with the chip not selected: the FSM goes to ST_IDLE.
- No strobe, from ST_READ or ST_WRITE: the burst continues into ST_READ or ST_WRITE, as the write controls of that cycle choose.
- No strobe, from ST_IDLE or ST_SLEEP: the FSM goes to ST_IDLE.
- Reset: the FSM goes to ST_IDLE.

Top module: `sbs_sram`

## Requirements
- R1: The chip is selected only when ce1_n=0, ce2=1 and ce3_n=0. A strobe while not selected starts no access and writes nothing. The deselect takes effect after a single edge: dq_valid goes low after the next edge in flow-through mode, and one edge later in pipelined mode.
- R2: A strobe on ld_proc or ld_ctrl loads addr as the base address and clears the beat count. A ld_proc strobe is always a read, whatever the write controls are, and it wins when both strobes are high. A ld_ctrl strobe writes when a write control is active.
- R3: During a burst, with no strobe, adv=1 steps the 2-bit beat count, wrapping from 3 to 0. With adv=0, the cycle accesses the same address again. The write controls of each beat decide whether that beat reads or writes.
- R4: With linear=1, the beat address keeps the upper bits of the base. Its two low bits are (base[1:0] + count) mod 4.
- R5: With linear=0 (interleaved), the two low bits are base[1:0] XOR count. The upper bits are unchanged.
- R6: With pipe_mode=0, the data of a read taken at edge k is on dq_out, with dq_valid=1, in the cycle after edge k.
- R7: With pipe_mode=1, the same data appears only after edge k+1. It is captured before any write made at edge k+1.
- R8: When bwr=1 and gwr=0, only the bytes whose bsel bit is 1 are written: bsel[0] selects bits 8:0 and bsel[1] selects bits 17:9. bwr=1 with bsel=00 writes nothing, and the beat is a read.
- R9: When gwr=1, the whole 18-bit word is written, whatever bwr and bsel are.
- R10: While sleep=1, dq_valid is 0 immediately. An edge that samples sleep=1 performs no read or write and clears any pending read data. Memory contents are kept.
- R11: dq_valid is 0 immediately while oe=0, and dq_out is 0 whenever dq_valid is 0.
- R12: A new address can be loaded on every consecutive edge, for reads or for writes, with no idle cycles in between.
- R13: After a synchronous reset, the FSM is in ST_IDLE and dq_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| ld_proc | input | 1 | Load strobe that always reads |
| ld_ctrl | input | 1 | Load strobe that may read or write |
| adv | input | 1 | Step the beat counter during a burst |
| addr | input | ADDR_W | External address |
| gwr | input | 1 | Global write, all bytes |
| bwr | input | 1 | Byte write enable |
| bsel | input | 2 | Per-byte write selects |
| din | input | 18 | Write data |
| linear | input | 1 | 1 = linear order, 0 = interleaved order |
| pipe_mode | input | 1 | 1 = pipelined read, 0 = flow-through read |
| oe | input | 1 | Output enable, asynchronous, active high |
| sleep | input | 1 | Low-power request, active high |
| dq_out | output | 18 | Read data, 0 when not valid |
| dq_valid | output | 1 | Output driven; low stands for tri-state |

## Verification
The embedded assertions check the following on every cycle:
- a ld_proc strobe lands in ST_READ;
- a strobe while deselected lands in ST_IDLE;
- any memory write is followed by ST_WRITE;
- sleep blocks writes;
- a burst beat without advance repeats its address;
- a flow-through read becomes pending pipelined data one edge later.

Some behaviour only the bench's scenarios can show. This covers the data values themselves: linear versus interleaved sequences across a wrap, byte merging, global write overriding the byte controls, retention through sleep, and the exact latency difference between the two read paths. Those scenarios are compared on each clock against a behavioural reference model.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int BYTE_W    = 9;
    localparam int NUM_BYTES = 2;
    localparam int WORD_W    = BYTE_W * NUM_BYTES;
    localparam int BEAT_W    = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } sbs_state_e;
endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              linear,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] eff_addr
);
    import sbs_pkg::*;

    logic [ADDR_W-1:0] base_q, base_e;
    logic [BEAT_W-1:0] cnt_q, cnt_e, low_e;

    always_comb begin
        base_e = load ? ld_addr : base_q;
        if (load)      cnt_e = '0;
        else if (step) cnt_e = BEAT_W'(cnt_q + 1'b1);
        else           cnt_e = cnt_q;
        low_e    = linear ? BEAT_W'(base_e[BEAT_W-1:0] + cnt_e)
                          : (base_e[BEAT_W-1:0] ^ cnt_e);
        eff_addr = {base_e[ADDR_W-1:BEAT_W], low_e};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_e;
            cnt_q  <= cnt_e;
        end
    end

    // R3: a beat that neither loads nor steps repeats the previous address
    assert_suspend_repeat_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !step && !$past(rst) && $stable(linear)) |-> (eff_addr == $past(eff_addr)));
endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
    parameter int ADDR_W = 6
) (
    input  logic                           clk,
    input  logic [sbs_pkg::NUM_BYTES-1:0]  wr_mask,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [sbs_pkg::WORD_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [sbs_pkg::WORD_W-1:0]     rd_data
);
    import sbs_pkg::*;
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_mask[b])
                store[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
        end
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/sbs_rd_path.sv
module sbs_rd_path #(
    parameter int ADDR_W = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sleep,
    input  logic                       rd_req,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       pipe_mode,
    input  logic                       oe,
    input  logic [sbs_pkg::WORD_W-1:0] mem_data,
    output logic [ADDR_W-1:0]          rd_addr_q,
    output logic [sbs_pkg::WORD_W-1:0] dq_out,
    output logic                       dq_valid
);
    import sbs_pkg::*;

    logic              rd_valid_q, pipe_valid_q, src_valid;
    logic [WORD_W-1:0] pipe_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr_q    <= '0;
            rd_valid_q   <= 1'b0;
            pipe_valid_q <= 1'b0;
            pipe_data_q  <= '0;
        end else begin
            if (rd_req) rd_addr_q <= req_addr;
            rd_valid_q   <= rd_req;
            pipe_valid_q <= rd_valid_q && !sleep;
            pipe_data_q  <= mem_data;
        end
    end

    always_comb begin
        src_valid = pipe_mode ? pipe_valid_q : rd_valid_q;
        dq_valid  = oe && !sleep && src_valid;
        dq_out    = dq_valid ? (pipe_mode ? pipe_data_q : mem_data) : '0;
    end

    // R7: a flow-through read turns into pending pipelined data one edge later
    assert_pipe_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_q && !sleep) |=> pipe_valid_q);
    // R10: a sleep edge never leaves a read pending
    assert_sleep_clears_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !rd_valid_q);
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              ld_proc,
    input  logic              ld_ctrl,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gwr,
    input  logic              bwr,
    input  logic [1:0]        bsel,
    input  logic [17:0]       din,
    input  logic              linear,
    input  logic              pipe_mode,
    input  logic              oe,
    input  logic              sleep,
    output logic [17:0]       dq_out,
    output logic              dq_valid
);
    import sbs_pkg::*;

    sbs_state_e           state, state_nxt;
    logic                 selected, strobe, wr_req;
    logic                 load, step, access, is_wr, rd_req;
    logic [NUM_BYTES-1:0] wr_mask;
    logic [ADDR_W-1:0]    eff_addr, rd_addr_q;
    logic [WORD_W-1:0]    mem_data;

    assign selected = !ce1_n && ce2 && !ce3_n;
    assign strobe   = ld_proc || ld_ctrl;
    assign wr_req   = gwr || (bwr && (|bsel));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // next state and access decode
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        step      = 1'b0;
        access    = 1'b0;
        is_wr     = 1'b0;
        if (sleep) begin
            state_nxt = ST_SLEEP;
        end else if (strobe) begin
            if (selected) begin
                load      = 1'b1;
                access    = 1'b1;
                is_wr     = !ld_proc && wr_req;
                state_nxt = is_wr ? ST_WRITE : ST_READ;
            end else begin
                state_nxt = ST_IDLE;
            end
        end else begin
            unique case (state)
                ST_READ, ST_WRITE: begin
                    access    = 1'b1;
                    step      = adv;
                    is_wr     = wr_req;
                    state_nxt = is_wr ? ST_WRITE : ST_READ;
                end
                ST_IDLE, ST_SLEEP: state_nxt = ST_IDLE;
            endcase
        end
    end

    // outputs of the FSM towards the datapath
    always_comb begin
        if (!is_wr)    wr_mask = '0;
        else if (gwr)  wr_mask = '1;
        else           wr_mask = bsel;
        rd_req = access && !is_wr;
    end

    sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .load(load), .step(step), .linear(linear),
        .ld_addr(addr), .eff_addr(eff_addr)
    );

    sbs_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .wr_mask(wr_mask), .wr_addr(eff_addr), .wr_data(din),
        .rd_addr(rd_addr_q), .rd_data(mem_data)
    );

    sbs_rd_path #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst), .sleep(sleep), .rd_req(rd_req), .req_addr(eff_addr),
        .pipe_mode(pipe_mode), .oe(oe), .mem_data(mem_data), .rd_addr_q(rd_addr_q),
        .dq_out(dq_out), .dq_valid(dq_valid)
    );

    // R2: a processor-side load is always a read
    assert_proc_read_R2: assert property (@(posedge clk) disable iff (rst)
        (ld_proc && selected && !sleep) |=> (state == ST_READ));
    // R1: a strobe while deselected ends in idle
    assert_deselect_R1: assert property (@(posedge clk) disable iff (rst)
        (strobe && !selected && !sleep) |=> (state == ST_IDLE));
    // R8: any memory write is recorded as a write beat
    assert_wr_state_R8: assert property (@(posedge clk) disable iff (rst)
        (|wr_mask) |=> (state == ST_WRITE));
    // R10: sleep blocks every write
    assert_sleep_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (wr_mask == '0));
endmodule

// File: tb/sbs_sram_tb.sv
module sbs_sram_tb;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, ce1_n, ce2, ce3_n, ld_proc, ld_ctrl, adv, gwr, bwr;
    logic linear, pipe_mode, oe, sleep, dq_valid;
    logic [AW-1:0] addr;
    logic [1:0]    bsel;
    logic [17:0]   din, dq_out;

    sbs_sram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .ld_proc(ld_proc), .ld_ctrl(ld_ctrl), .adv(adv), .addr(addr),
        .gwr(gwr), .bwr(bwr), .bsel(bsel), .din(din), .linear(linear),
        .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep),
        .dq_out(dq_out), .dq_valid(dq_valid)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R13";
    bit    done = 0;

    // reference model state
    logic [17:0] mmem [DEPTH];
    int          m_state = 0;   // 0 idle, 1 read, 2 write, 3 sleep
    int          m_base = 0, m_cnt = 0, m_rdaddr = 0;
    bit          m_rdv = 0, m_pipev = 0;
    logic [17:0] m_pipe = '0;

    task automatic model_step();
        bit sel, str, wrq, acc, isw;
        int ea;
        if (rst) begin
            m_state = 0; m_base = 0; m_cnt = 0; m_rdaddr = 0;
            m_rdv = 0; m_pipev = 0;
            return;
        end
        m_pipev = m_rdv && !sleep;
        m_pipe  = mmem[m_rdaddr];
        sel = !ce1_n && ce2 && !ce3_n;
        str = ld_proc || ld_ctrl;
        wrq = gwr || (bwr && (bsel != 2'b00));
        acc = 0; isw = 0;
        if (sleep) m_state = 3;
        else if (str) begin
            if (sel) begin
                m_base = int'(addr); m_cnt = 0; acc = 1;
                isw = !ld_proc && wrq;
                m_state = isw ? 2 : 1;
            end else m_state = 0;
        end else if (m_state == 1 || m_state == 2) begin
            acc = 1;
            if (adv) m_cnt = (m_cnt + 1) % 4;
            isw = wrq;
            m_state = isw ? 2 : 1;
        end else m_state = 0;
        if (acc) begin
            if (linear) ea = (m_base & ~3) | ((m_base + m_cnt) & 3);
            else        ea = (m_base & ~3) | ((m_base ^ m_cnt) & 3);
            if (isw) begin
                if (gwr) mmem[ea] = din;
                else begin
                    if (bsel[0]) mmem[ea][8:0]  = din[8:0];
                    if (bsel[1]) mmem[ea][17:9] = din[17:9];
                end
            end else m_rdaddr = ea;
        end
        m_rdv = acc && !isw;
    endtask

    task automatic compare();
        bit          ev;
        logic [17:0] ed;
        ev = oe && !sleep && (pipe_mode ? m_pipev : m_rdv);
        ed = ev ? (pipe_mode ? m_pipe : mmem[m_rdaddr]) : 18'h0;
        n_chk++;
        if (dq_valid !== ev || dq_out !== ed) begin
            n_fail++;
            $display("FAIL %s t=%0t actual valid=%0b data=%h expected valid=%0b data=%h",
                     cur_req, $time, dq_valid, dq_out, ev, ed);
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #2;
        if (!done) compare();
    end

    task automatic cyc(input bit p, input bit c, input bit av, input int a,
                       input bit g, input bit b, input logic [1:0] bs, input logic [17:0] d);
        ld_proc = p; ld_ctrl = c; adv = av; addr = AW'(a);
        gwr = g; bwr = b; bsel = bs; din = d;
        @(negedge clk);
    endtask

    task automatic desel();
        ce1_n = 1'b1;
        cyc(1, 0, 0, 0, 0, 0, 2'b00, 18'h0);
        ce1_n = 1'b0;
    endtask

    task automatic rd(input int a);
        cyc(1, 0, 0, a, 0, 0, 2'b00, 18'h0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R13 actual=timeout expected=completion");
        done = 1;
        report();
    end

    initial begin
        rst = 1; ce1_n = 0; ce2 = 1; ce3_n = 0; ld_proc = 0; ld_ctrl = 0; adv = 0;
        addr = '0; gwr = 0; bwr = 0; bsel = 2'b00; din = '0;
        linear = 0; pipe_mode = 1; oe = 1; sleep = 0;
        repeat (3) @(negedge clk);
        // R13: explicit reset state check
        n_chk++;
        if (dq_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R13 reset actual valid=%0b expected valid=0", dq_valid);
        end
        rst = 0;

        // R12 / R9: fill memory with one global write per cycle
        cur_req = "R12_R9";
        for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, i, 1, 0, 2'b00, 18'((i * 1031 + 77) & 18'h3ffff));
        desel();

        // R6: flow-through reads, new address every cycle
        cur_req = "R6_R12"; pipe_mode = 0;
        for (int i = 0; i < 8; i++) rd((i * 5) % DEPTH);
        desel(); desel();

        // R7: pipelined reads
        cur_req = "R7"; pipe_mode = 1;
        for (int i = 0; i < 8; i++) rd((i * 7 + 3) % DEPTH);
        desel(); desel();

        // R4 / R3: linear burst with suspend and wrap
        cur_req = "R4_R3"; linear = 1;
        rd(6);
        cyc(0, 0, 1, 0, 0, 0, 2'b00, 0);
        cyc(0, 0, 0, 0, 0, 0, 2'b00, 0);
        cyc(0, 0, 1, 0, 0, 0, 2'b00, 0);
        cyc(0, 0, 1, 0, 0, 0, 2'b00, 0);
        cyc(0, 0, 1, 0, 0, 0, 2'b00, 0);
        desel(); desel();

        // R5: interleaved burst, flow-through
        cur_req = "R5"; linear = 0; pipe_mode = 0;
        rd(7);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0, 2'b00, 0);
        desel(); desel();

        // R8 / R9: byte and global writes, then a burst write
        cur_req = "R8_R9";
        cyc(0, 1, 0, 10, 0, 1, 2'b01, 18'h3ffff);
        cyc(0, 1, 0, 11, 0, 1, 2'b10, 18'h3ffff);
        cyc(0, 1, 0, 12, 0, 1, 2'b00, 18'h3ffff);
        cyc(0, 1, 0, 13, 1, 0, 2'b00, 18'h15a5a);
        cyc(0, 1, 0, 14, 1, 1, 2'b01, 18'h2c3c3);
        cyc(0, 1, 0, 20, 1, 0, 2'b00, 18'h00111);
        cyc(0, 0, 1, 0, 0, 1, 2'b10, 18'h22200);
        cyc(0, 0, 1, 0, 1, 0, 2'b00, 18'h33333);
        desel();
        for (int a = 10; a < 15; a++) rd(a);
        for (int a = 20; a < 24; a++) rd(a);
        desel();

        // R2: processor strobe is always a read
        cur_req = "R2"; pipe_mode = 1;
        cyc(1, 0, 0, 15, 1, 0, 2'b00, 18'h0abcd);
        cyc(1, 1, 0, 15, 1, 1, 2'b11, 18'h0dcba);
        rd(15);
        desel(); desel();

        // R1: each chip-enable alone deselects
        cur_req = "R1";
        ce1_n = 1; cyc(0, 1, 0, 16, 1, 0, 2'b00, 18'h11111); ce1_n = 0;
        ce2 = 0;   cyc(0, 1, 0, 16, 1, 0, 2'b00, 18'h22222); ce2 = 1;
        ce3_n = 1; cyc(0, 1, 0, 16, 1, 0, 2'b00, 18'h33333); ce3_n = 0;
        rd(16); rd(17);
        ce3_n = 1; cyc(1, 0, 0, 0, 0, 0, 2'b00, 0); ce3_n = 0;
        desel();

        // R11: output enable masks data at once
        cur_req = "R11"; pipe_mode = 0;
        rd(30); oe = 0; rd(31); rd(32); oe = 1; rd(33);
        desel();

        // R10: sleep blocks accesses and keeps memory
        cur_req = "R10"; pipe_mode = 1;
        rd(40); rd(41);
        sleep = 1;
        cyc(0, 1, 0, 17, 1, 0, 2'b00, 18'h3f00f);
        cyc(0, 1, 0, 40, 1, 0, 2'b00, 18'h3f00f);
        cyc(0, 0, 1, 0, 0, 0, 2'b00, 0);
        sleep = 0;
        rd(17); rd(40);
        desel(); desel();

        done = 1;
        report();
    end
endmodule